// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address presented to a synchronous memory array during a four-beat burst. A new cycle begins when either of two address strobes is seen at a clock edge. The full external address is then captured. Its upper bits are held for the rest of the burst, and its two low bits become the starting offset of the burst.

On each later edge where the advance input is high, the block steps to the next burst position. When advance is low, the current position is held, which suspends the burst. A static order-select input picks the sequence:

- **Linear order:** the offset counts up from the start, modulo four.
- **Interleaved order:** the offset is the start XOR a beat count that runs from zero to three.

Both orders return to the starting offset after four beats. The strobes arrive already qualified by the chip-select logic in front of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `burstAddr` reads all zeros.
- R2: If `startA` or `startB` is high at a rising edge, `burstAddr` equals the `extAddr` sampled at that edge from the following cycle on. This holds in both orders, and a strobe takes precedence over a simultaneous `advEn`.
- R3: With `orderSel`=0, each edge with `advEn`=1 and no strobe adds one, modulo 4, to the offset (`burstAddr[1:0]`). A start of 01 gives 01, 10, 11, 00.
- R4: With `orderSel`=1, the offset equals the start XOR the number of advancing edges since the load, modulo 4. A start of 01 gives 01, 00, 11, 10; a start of 10 gives 10, 11, 00, 01.
- R5: An edge with `advEn`=0 and no strobe leaves `burstAddr` unchanged.
- R6: The upper bits `burstAddr[15:2]` keep the loaded value until the next strobe, whatever `extAddr` does in between.
- R7: After four advancing edges, the offset returns to the starting offset in either order.
- R8: `orderSel` is not registered. Changing it mid-burst re-forms the offset from the same start and beat count without disturbing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startA | input | 1 | First qualified address strobe, active high |
| startB | input | 1 | Second qualified address strobe, active high |
| advEn | input | 1 | Step to the next burst position |
| orderSel | input | 1 | 0 = linear order, 1 = interleaved order |
| extAddr | input | 16 | External address captured on a strobe |
| burstAddr | output | 16 | Address sent to the memory array |

## Verification
The properties assume that `orderSel` is static. Each property that could be upset by a change of order carries an escape: it is excused in any cycle where `orderSel` differs from its previous value. The properties also assume that the strobes are already qualified, so any strobe counts as a load.

The stimulus changes `orderSel` only between bursts, or in one deliberate mid-burst step that checks R8, where the escape applies. All inputs are driven on the falling edge, so setup is never violated.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture external address, clear beat count
    logic step;   // advance beat count by one
  } burstCtl_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic      startA,
  input  logic      startB,
  input  logic      advEn,
  output burstCtl_t ctl
);
  // A strobe starts a new cycle and wins over advance
  always_comb begin
    ctl.load = startA | startB;
    ctl.step = advEn & ~(startA | startB);
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  burstCtl_t     ctl,
  input  logic          orderSel,
  input  logic [AW-1:0] extAddr,
  output logic [AW-1:0] burstAddr
);
  localparam int UW = AW - OW;
  localparam logic [OW-1:0] ONE = OW'(1);

  logic [UW-1:0] upperReg;
  logic [OW-1:0] startReg;
  logic [OW-1:0] countReg;
  logic [OW-1:0] offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      startReg <= '0;
      countReg <= '0;
    end else if (ctl.load) begin
      upperReg <= extAddr[AW-1:OW];
      startReg <= extAddr[OW-1:0];
      countReg <= '0;
    end else if (ctl.step) begin
      countReg <= countReg + ONE;
    end
  end

  // Order select is static and applied combinationally
  always_comb begin
    if (orderSel) offset = startReg ^ countReg;
    else          offset = startReg + countReg;
  end

  assign burstAddr = {upperReg, offset};

  // R4: in interleaved order, output XOR start advances by one per step
  p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && orderSel) |=>
      (!orderSel || ((offset ^ startReg) == (($past(offset) ^ $past(startReg)) + ONE))));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startA,
  input  logic          startB,
  input  logic          advEn,
  input  logic          orderSel,
  input  logic [AW-1:0] extAddr,
  output logic [AW-1:0] burstAddr
);
  localparam logic [OW-1:0] ONE = OW'(1);

  burstCtl_t ctl;

  burst_ctl u_ctl (
    .startA (startA),
    .startB (startB),
    .advEn  (advEn),
    .ctl    (ctl)
  );

  burst_dp #(.AW(AW), .OW(OW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .orderSel  (orderSel),
    .extAddr   (extAddr),
    .burstAddr (burstAddr)
  );

  // R2: a strobe loads the whole external address
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startA || startB) |=> (burstAddr == $past(extAddr)));

  // R3: linear step adds one to the offset
  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!startA && !startB && advEn && !orderSel) |=>
      (orderSel || (burstAddr[OW-1:0] == ($past(burstAddr[OW-1:0]) + ONE))));

  // R5: no strobe and no advance holds the address
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!startA && !startB && !advEn) |=>
      ($stable(burstAddr) || (orderSel != $past(orderSel))));

  // R6: upper bits only change on a strobe
  p_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!startA && !startB) |=> $stable(burstAddr[AW-1:OW]));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startA = 1'b0, startB = 1'b0, advEn = 1'b0, orderSel = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] burstAddr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } item_t;
  item_t q[$];

  // Bench-side view of the burst state
  logic [AW-3:0] mUp = '0;
  logic [1:0]    mStart = '0;
  logic [1:0]    mCnt = '0;

  always #10 clk = ~clk;

  burst_addr_gen uut (
    .clk(clk), .rstN(rstN), .startA(startA), .startB(startB),
    .advEn(advEn), .orderSel(orderSel), .extAddr(extAddr),
    .burstAddr(burstAddr)
  );

  function automatic logic [AW-1:0] expAddr(input logic mode);
    logic [1:0] off;
    off = mode ? (mStart ^ mCnt) : (mStart + mCnt);
    return {mUp, off};
  endfunction

  task automatic drive(input logic sa, input logic sb, input logic adv,
                       input logic mode, input logic [AW-1:0] a, input string req);
    item_t it;
    @(negedge clk);
    startA = sa; startB = sb; advEn = adv; orderSel = mode; extAddr = a;
    if (sa || sb) begin
      mUp = a[AW-1:2]; mStart = a[1:0]; mCnt = 2'd0;
    end else if (adv) begin
      mCnt = mCnt + 2'd1;
    end
    it.exp = expAddr(mode);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic direct(input logic [AW-1:0] exp, input string req);
    checks++;
    if (burstAddr !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, burstAddr, exp);
    end
  endtask

  // Monitor: compare one expectation after every rising edge
  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (burstAddr !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.req, burstAddr, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    direct(16'h0000, "R1 in reset");
    rstN = 1'b1;
    @(posedge clk); #5;
    direct(16'h0000, "R1 after reset");

    // R3 / R7: linear from 01 gives 01 10 11 00 then wraps to 01
    drive(1, 0, 0, 0, 16'h1231, "R2 load linear");
    drive(0, 0, 1, 0, 16'h0000, "R3 beat2 10");
    drive(0, 0, 1, 0, 16'hFFFF, "R3 beat3 11");
    drive(0, 0, 1, 0, 16'h5555, "R3 beat4 00");
    drive(0, 0, 1, 0, 16'h0000, "R7 linear wrap");

    // R5: hold while advance low
    drive(0, 0, 0, 0, 16'hAAAA, "R5 hold");
    drive(0, 0, 0, 0, 16'h0F0F, "R5 hold");

    // R4 / R7: interleaved from 01 gives 01 00 11 10 then 01
    drive(0, 1, 0, 1, 16'hABC1, "R2 load via startB");
    drive(0, 0, 1, 1, 16'h0000, "R4 beat2 00");
    drive(0, 0, 1, 1, 16'h0000, "R4 beat3 11");
    drive(0, 0, 1, 1, 16'h0000, "R4 beat4 10");
    drive(0, 0, 1, 1, 16'h0000, "R7 interleaved wrap");

    // R4: interleaved from 10 gives 10 11 00 01, with suspend in between
    drive(1, 0, 0, 1, 16'h0002, "R2 load 10");
    drive(0, 0, 1, 1, 16'h1234, "R4 start10 beat2 11 R6");
    drive(0, 0, 0, 1, 16'h4321, "R5 suspend interleaved");
    drive(0, 0, 1, 1, 16'hFFFF, "R4 start10 beat3 00 R6");
    drive(0, 0, 1, 1, 16'h8000, "R4 start10 beat4 01");

    // R2: strobe wins over advance
    drive(1, 1, 1, 0, 16'h7FFE, "R2 strobe over advance");
    drive(1, 0, 1, 0, 16'h0003, "R2 reload over advance");
    drive(0, 0, 1, 0, 16'hFFFC, "R6 upper kept, R3 11 to 00");

    // R8: order change mid-burst re-forms offset from same count
    drive(1, 0, 0, 0, 16'h4441, "R2 load for R8");
    drive(0, 0, 1, 0, 16'h0000, "R3 linear 10");
    drive(0, 0, 0, 1, 16'h0000, "R8 switch to interleaved 00");
    drive(0, 0, 1, 1, 16'h0000, "R8 count kept, 11");
    drive(0, 0, 0, 0, 16'h0000, "R8 switch back linear 11");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule